// File: doc/BRIEF.md
# Serial Bus Transceiver Mode Controller

This block is the digital mode sequencer for a clock-extension serial bus transceiver. It takes a sleep-control pin, a master/slave role select, the transmit-data level, synchronised over-temperature and low-supply flags, and a one-cycle pulse for each baud clock edge. From these it tracks the operating mode and drives the enables for the bus output stage, the transmit path, the receive-data pin and the clock pin.

There are six modes. Low-power reset holds every output off. Sleep and standby are the quiet modes. Normal is the communicating mode. Wakeup-pulse output lets a slave pass an unencoded low pulse onto the bus. Thermal shutdown disables the driver while reception continues. The controller also guards against a stuck-low transmit line: the transmit path is only armed after the line has been seen high following entry to normal mode or recovery from a thermal event. The bus driver is only released after a fixed number of baud edges.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: When the low-supply flag drops, the mode becomes standby if the sleep-control input is high, and sleep if it is low. Mode codes are: reset 0, sleep 1, standby 2, normal 3, wakeup 4, thermal 5.
- R2: While the low-supply flag is high, the controller enters and stays in reset mode, whatever the current mode. In reset mode the bus, receive and clock enables are all low.
- R3: In normal mode, the tx enable drops in the same cycle that sleep-control goes low. The mode moves to sleep at the first edge where sleep-control is low and transmit data is high. If transmit data is low, the mode stays normal.
- R4: Standby lasts MODE_CHG_CYC cycles with sleep-control held high and then becomes normal. If sleep-control goes low, the mode returns to sleep and the count starts again. In standby all enables are low.
- R5: After entry to normal mode, the bus enable stays low until BAUD_WAIT baud ticks have been counted in normal mode.
- R6: An over-temperature flag in normal mode moves the mode to thermal. In thermal mode the bus enable is low and the receive enable stays high. When the flag clears, the mode returns to normal.
- R7: The over-temperature flag has no effect in sleep mode.
- R8: In normal mode, the tx enable requires transmit data to have been seen high at an edge since the last entry into normal mode. That entry can be from standby or from thermal.
- R9: The role select is latched only in reset and sleep modes. If the select differs from the latched role in any other mode, the role error output goes high. It stays high until a cycle that begins in sleep mode.
- R10: A slave in sleep mode that has seen transmit data high and then sees it low enters wakeup mode, with bus and tx enables high. Transmit data going high returns the mode to sleep.
- R11: In sleep mode, a master drives the receive pin (receive enable high, clock enable low). A slave drives the clock pin instead (clock enable high, receive enable low). In normal mode the clock enable follows the slave role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_n_i | input | 1 | Sleep control; high requests normal operation |
| sel_slave_i | input | 1 | Role select; 1 = slave, 0 = master |
| txd_i | input | 1 | Transmit data level |
| ovr_temp_i | input | 1 | Synchronised over-temperature flag |
| supply_low_i | input | 1 | Synchronised low-supply flag |
| baud_tick_i | input | 1 | One-cycle pulse per baud clock edge |
| mode_o | output | 3 | Current mode code |
| bus_en_o | output | 1 | Bus output stage enabled (else high impedance) |
| tx_en_o | output | 1 | Transmit data passed to the bus |
| rxd_en_o | output | 1 | Receive-data pin driven |
| clk_en_o | output | 1 | Clock pin driven by this node |
| role_err_o | output | 1 | Role select changed outside sleep |

## Verification
A wrong internal mode shows on mode_o one edge after the input that caused it. The enable pattern tied to each mode shows it in the same cycle. A wrong dwell or baud count shows as a mode change or a bus enable that is one or more cycles early or late, so the tests sample at the exact boundary edge and one edge before it. A missing transmit interlock shows as tx_en_o rising while transmit data has been low since entry. A broken sleep gate shows as tx_en_o staying high in the cycle that sleep-control falls.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  typedef enum logic [2:0] {
    MD_RESET   = 3'd0,
    MD_SLEEP   = 3'd1,
    MD_STANDBY = 3'd2,
    MD_NORMAL  = 3'd3,
    MD_WAKE    = 3'd4,
    MD_THERMAL = 3'd5
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_dwell_timer.sv
module xcvr_dwell_timer #(
  parameter int unsigned CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xcvr_baud_gate.sv
module xcvr_baud_gate #(
  parameter int unsigned TICKS = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  assign ready_o = (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (tick_i && !ready_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xcvr_txd_arm.sv
module xcvr_txd_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic keep_i,
  input  logic txd_i,
  output logic armed_o
);
  // arms on a high txd level, drops whenever the qualifying window closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_o <= 1'b0;
    else if (!keep_i) armed_o <= 1'b0;
    else if (txd_i)   armed_o <= 1'b1;
  end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned MODE_CHG_CYC = 125000,
  parameter int unsigned BAUD_WAIT    = 33
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_n_i,
  input  logic       sel_slave_i,
  input  logic       txd_i,
  input  logic       ovr_temp_i,
  input  logic       supply_low_i,
  input  logic       baud_tick_i,
  output logic [2:0] mode_o,
  output logic       bus_en_o,
  output logic       tx_en_o,
  output logic       rxd_en_o,
  output logic       clk_en_o,
  output logic       role_err_o
);
  xcvr_mode_e mode_q, mode_d;
  logic role_q, err_q, from_wake_q;
  logic dwell_done, bus_ready, norm_armed, wake_armed;
  logic in_normal, in_latch_mode;

  assign in_normal     = (mode_q == MD_NORMAL);
  assign in_latch_mode = (mode_q == MD_SLEEP) || (mode_q == MD_RESET);

  xcvr_dwell_timer #(.CYCLES(MODE_CHG_CYC)) i_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((mode_q == MD_STANDBY) && sleep_n_i),
    .done_o (dwell_done)
  );

  xcvr_baud_gate #(.TICKS(BAUD_WAIT)) i_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!(in_normal || (mode_q == MD_THERMAL))),
    .tick_i  (baud_tick_i && in_normal),
    .ready_o (bus_ready)
  );

  xcvr_txd_arm i_norm_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .keep_i  (in_normal),
    .txd_i   (txd_i),
    .armed_o (norm_armed)
  );

  xcvr_txd_arm i_wake_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .keep_i  ((mode_q == MD_SLEEP) || (mode_q == MD_WAKE)),
    .txd_i   (txd_i),
    .armed_o (wake_armed)
  );

  always_comb begin
    mode_d = mode_q;
    if (supply_low_i) begin
      mode_d = MD_RESET;
    end else begin
      unique case (mode_q)
        MD_RESET:   mode_d = sleep_n_i ? MD_STANDBY : MD_SLEEP;
        MD_SLEEP: begin
          if (sleep_n_i)                             mode_d = MD_STANDBY;
          else if (role_q && wake_armed && !txd_i)   mode_d = MD_WAKE;
        end
        MD_STANDBY: begin
          if (!sleep_n_i)      mode_d = MD_SLEEP;
          else if (dwell_done) mode_d = MD_NORMAL;
        end
        MD_NORMAL: begin
          if (!sleep_n_i && txd_i) mode_d = MD_SLEEP;
          else if (ovr_temp_i)     mode_d = MD_THERMAL;
        end
        MD_WAKE: begin
          if (sleep_n_i)       mode_d = MD_STANDBY;
          else if (ovr_temp_i) mode_d = MD_THERMAL;
          else if (txd_i)      mode_d = MD_SLEEP;
        end
        MD_THERMAL: begin
          if (from_wake_q) begin
            if (sleep_n_i)        mode_d = MD_STANDBY;
            else if (!ovr_temp_i) mode_d = MD_SLEEP;
          end else begin
            if (!sleep_n_i)       mode_d = MD_SLEEP;
            else if (!ovr_temp_i) mode_d = MD_NORMAL;
          end
        end
        default:    mode_d = MD_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MD_RESET;
      role_q      <= 1'b0;
      err_q       <= 1'b0;
      from_wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (in_latch_mode) role_q <= sel_slave_i;
      if (mode_q == MD_SLEEP)       err_q <= 1'b0;
      else if (mode_q != MD_RESET)  err_q <= err_q | (sel_slave_i != role_q);
      if (mode_d == MD_THERMAL && mode_q != MD_THERMAL)
        from_wake_q <= (mode_q == MD_WAKE);
    end
  end

  always_comb begin
    bus_en_o = 1'b0;
    tx_en_o  = 1'b0;
    rxd_en_o = 1'b0;
    clk_en_o = 1'b0;
    unique case (mode_q)
      MD_SLEEP: begin
        rxd_en_o = !role_q;
        clk_en_o = role_q;
      end
      MD_NORMAL: begin
        bus_en_o = bus_ready;
        tx_en_o  = bus_ready && norm_armed && sleep_n_i;
        rxd_en_o = 1'b1;
        clk_en_o = role_q;
      end
      MD_WAKE: begin
        bus_en_o = 1'b1;
        tx_en_o  = 1'b1;
        clk_en_o = role_q;
      end
      MD_THERMAL: begin
        rxd_en_o = 1'b1;
        clk_en_o = role_q;
      end
      default: ;
    endcase
  end

  assign mode_o     = mode_q;
  assign role_err_o = err_q;
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk
  import xcvr_mode_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_n_i,
  input logic       supply_low_i,
  input logic [2:0] mode_o,
  input logic       bus_en_o,
  input logic       tx_en_o,
  input logic       rxd_en_o,
  input logic       clk_en_o
);
  assert_reset_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |=> (mode_o == MD_RESET) && !bus_en_o && !rxd_en_o && !clk_en_o);

  assert_tx_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_NORMAL) && !sleep_n_i |-> !tx_en_o);

  assert_standby_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_STANDBY) |-> !bus_en_o && !tx_en_o && !rxd_en_o && !clk_en_o);

  assert_tx_needs_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_NORMAL) && tx_en_o |-> bus_en_o);

  assert_thermal_bus_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_THERMAL) |-> !bus_en_o && rxd_en_o);

  assert_sleep_no_thermal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_SLEEP) |=> (mode_o != MD_THERMAL));

  assert_entry_unarmed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MD_STANDBY) |=> !tx_en_o);
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_n_i    (sleep_n_i),
  .supply_low_i (supply_low_i),
  .mode_o       (mode_o),
  .bus_en_o     (bus_en_o),
  .tx_en_o      (tx_en_o),
  .rxd_en_o     (rxd_en_o),
  .clk_en_o     (clk_en_o)
);

// File: tb/test_xcvr_mode_ctrl.sv
module test_xcvr_mode_ctrl;
  localparam int unsigned MCC = 4;
  localparam int unsigned BW  = 3;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sn = 1'b0, sel = 1'b0, txd = 1'b1, ot = 1'b0, sl = 1'b1, tk = 1'b0;
  logic [2:0] mode;
  logic bus_en, tx_en, rxd_en, clk_en, role_err;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xcvr_mode_ctrl #(.MODE_CHG_CYC(MCC), .BAUD_WAIT(BW)) i_xcvr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_n_i(sn), .sel_slave_i(sel),
    .txd_i(txd), .ovr_temp_i(ot), .supply_low_i(sl), .baud_tick_i(tk),
    .mode_o(mode), .bus_en_o(bus_en), .tx_en_o(tx_en), .rxd_en_o(rxd_en),
    .clk_en_o(clk_en), .role_err_o(role_err)
  );

  // {sn,sel,txd,ot,sl,tk}, req, mode, {bus,tx,rxd,clk}
  localparam logic [16:0] VEC [NV] = '{
    {6'b001010, 4'd2,  3'd0, 4'b0000},  // R2 held in reset
    {6'b001000, 4'd1,  3'd1, 4'b0010},  // R1 release to sleep
    {6'b001100, 4'd7,  3'd1, 4'b0010},  // R7 over-temp ignored
    {6'b101000, 4'd4,  3'd2, 4'b0000},  // R4 standby
    {6'b101000, 4'd4,  3'd2, 4'b0000},
    {6'b101000, 4'd4,  3'd2, 4'b0000},
    {6'b101000, 4'd4,  3'd2, 4'b0000},
    {6'b100000, 4'd8,  3'd3, 4'b0010},  // R8 normal, txd low
    {6'b100001, 4'd5,  3'd3, 4'b0010},  // R5 counting
    {6'b100001, 4'd5,  3'd3, 4'b0010},
    {6'b100001, 4'd5,  3'd3, 4'b1010},
    {6'b101000, 4'd8,  3'd3, 4'b1110},  // R8 armed
    {6'b100000, 4'd8,  3'd3, 4'b1110},
    {6'b100100, 4'd6,  3'd5, 4'b0010},  // R6 thermal
    {6'b100000, 4'd6,  3'd3, 4'b1010},  // R6 back, R8 disarmed
    {6'b101000, 4'd8,  3'd3, 4'b1110},
    {6'b001000, 4'd3,  3'd1, 4'b0010}   // R3 to sleep
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset state", {mode, bus_en, tx_en, rxd_en, clk_en, role_err}, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {sn, sel, txd, ot, sl, tk} = VEC[i][16:11];
      step();
      chk($sformatf("R%0d vec %0d", VEC[i][10:7], i),
          {mode, bus_en, tx_en, rxd_en, clk_en}, int'(VEC[i][6:0]));
    end

    // R4 restart when sleep control drops
    sn = 1; step();
    chk("R4 enter standby", mode, 2);
    step(); step();
    sn = 0; step();
    chk("R4 abort to sleep", mode, 1);
    sn = 1; step(); step(); step(); step();
    chk("R4 count restarted", mode, 2);
    step();
    chk("R4 dwell done", mode, 3);

    // R2 / R1 supply dip from normal
    sl = 1; step();
    chk("R2 supply low", {mode, bus_en, rxd_en, clk_en}, 0);
    sl = 0; step();
    chk("R1 release to standby", mode, 2);
    step(); step(); step(); step();
    chk("R4 normal again", mode, 3);

    // R5 baud wait boundary
    tk = 1; step(); step();
    chk("R5 bus still off", bus_en, 0);
    step();
    chk("R5 bus on", bus_en, 1);
    tk = 0;
    chk("R8 armed with txd high", tx_en, 1);

    // R3 same-cycle disable
    sn = 0; txd = 0; #1;
    chk("R3 tx off same cycle", tx_en, 0);
    step();
    chk("R3 stays normal with txd low", mode, 3);
    txd = 1; step();
    chk("R3 sleep on txd high", mode, 1);

    ot = 1; step();
    chk("R7 sleep ignores over-temp", mode, 1);
    ot = 0;

    // R11 / R10 slave in sleep and wakeup pulse
    sel = 1; step();
    chk("R11 slave sleep pins", {mode, clk_en, rxd_en}, {3'd1, 1'b1, 1'b0});
    txd = 0; step();
    chk("R10 wakeup pulse", {mode, bus_en, tx_en, clk_en}, {3'd4, 3'b111});
    txd = 1; step();
    chk("R10 back to sleep", mode, 1);

    // R9 role change outside sleep
    sn = 1; step();
    sel = 0; step();
    chk("R9 role error raised", role_err, 1);
    sn = 0; step(); step();
    chk("R9 role error cleared", role_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule